// File: doc/BRIEF.md
# Pulse Burst Thermal Limiter

This block sits in the path of an asynchronous pulse train and lets pulses through only while a simple thermal budget holds. The pulse input is brought into the clock domain by a two-stage synchroniser, and a third stage provides rising-edge and falling-edge detection. The output is the synchronised pulse level ANDed with a gate flop. That flop is loaded only when the synchronised input falls, so a pulse that has already started always runs to its end.

Every pulse that is passed adds a fixed heat increment to an unsigned temperature-rise register. While the input rests low, a period counter measures idle time. Each full idle period subtracts one entry of a parameter cooling table, and a wrapping index selects which entry. A three-state controller (IDLE, PASS, BLOCKED) moves to BLOCKED when the temperature rise reaches its ceiling. While in BLOCKED it closes the gate at the next falling edge of the input. It leaves BLOCKED once cooling has brought the value below a lower release threshold.

Top module: `burst_thermal_limiter`

## Requirements
- R1: While rst_n is low, pulse_out is 0. After reset the gate is closed, the controller is in IDLE, and the temperature rise and both counters are zero.
- R2: pulse_in passes through two synchroniser flops. A level change applied before clock edge k shows at pulse_out after edge k+1, provided the gate is open.
- R3: The gate changes only in the cycle in which the synchronised input falls. Changing en in the middle of a pulse neither cuts short nor starts a pulse at pulse_out.
- R4: pulse_out equals the gate ANDed with the synchronised pulse level. With en held at 0, pulse_out stays at 0.
- R5: Each rising edge that reaches pulse_out adds HEAT to the temperature rise, saturating at MAX_RISE.
- R6: Once the temperature rise reaches MAX_RISE, the controller enters BLOCKED. In BLOCKED, the gate is loaded with 0 at the next falling edge, and no later pulse reaches pulse_out until release.
- R7: While the synchronised input is low, the idle counter counts up to RES-2. On the next low cycle it returns to 0, one cooling step is applied, and the table index advances. The index counts 0..LEN-1 and wraps to 0. Entry i is COOL_TBL[i*TW +: TW].
- R8: A cooling step subtracts the selected entry when the temperature rise is at least that entry. Otherwise it sets the temperature rise to 0.
- R9: BLOCKED is left when the temperature rise is below LOW_RISE. The controller goes to PASS if en is 1 and to IDLE otherwise, and the gate reopens at the next falling edge while en is 1.
- R10: A rising edge seen while en is 1 and the controller is not in BLOCKED clears both the idle counter and the table index.
- R11: The table index never reaches LEN, and the temperature rise never exceeds MAX_RISE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable, sampled into the gate at falling edges of the pulse train |
| pulse_in | input | 1 | Asynchronous incoming pulse train |
| pulse_out | output | 1 | Gated, synchronised pulse train |

## Verification
The case that needs the most care is a cooling step that completes in the same cycle as a falling edge of the input. This can happen because the idle counter is not cleared by pulses while the controller is in BLOCKED. If that cooling step releases the controller, the gate must still sample the old BLOCKED state and stay closed until the next falling edge. The bench sets this up in two ways. It holds the block at the ceiling and then sends pulses whose widths are chosen at random against the idle period. It also sends long random mixed traffic. A cycle-by-cycle reference model in the bench judges the outcome by comparing pulse_out against the model every cycle.

// File: rtl/burst_thermal_limiter.sv
module burst_thermal_limiter #(
  parameter int TW        = 8,
  parameter int RES       = 6,
  parameter int LEN       = 4,
  parameter int MAX_RISE  = 40,
  parameter int LOW_RISE  = 10,
  parameter int HEAT      = 8,
  parameter logic [LEN*TW-1:0] COOL_TBL = {8'd4, 8'd3, 8'd2, 8'd1}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse_in,
  output logic pulse_out
);

  localparam int SW = $clog2(RES);
  localparam int IW = $clog2(LEN) + 1;
  localparam logic [TW-1:0] MAXV  = TW'(MAX_RISE);
  localparam logic [TW-1:0] LOWV  = TW'(LOW_RISE);
  localparam logic [TW-1:0] HEATV = TW'(HEAT);
  localparam logic [TW-1:0] SATV  = TW'(MAX_RISE - HEAT);
  localparam logic [SW-1:0] SLIM  = SW'(RES - 2);
  localparam logic [IW-1:0] ILAST = IW'(LEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PASS, ST_BLOCKED} st_t;

  logic          s1, s2, s3, rise, fall, gate, blk, period_done;
  logic [SW-1:0] single_cnt;
  logic [IW-1:0] idx;
  logic [TW-1:0] temp, step;
  st_t           state;

  assign rise        = s2 & ~s3;
  assign fall        = ~s2 & s3;
  assign blk         = (state == ST_BLOCKED);
  assign pulse_out   = gate & s2;
  assign period_done = ~s2 & (single_cnt >= SLIM);
  assign step        = COOL_TBL[int'(idx)*TW +: TW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pulse_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    gate <= 1'b0;
    else if (fall) gate <= blk ? 1'b0 : en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_cnt <= '0;
      idx        <= '0;
    end else if (rise && en && !blk) begin
      single_cnt <= '0;
      idx        <= '0;
    end else if (!s2) begin
      if (single_cnt < SLIM) begin
        single_cnt <= single_cnt + 1'b1;
      end else begin
        single_cnt <= '0;
        idx        <= (idx < ILAST) ? idx + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      temp <= '0;
    else if (period_done)
      temp <= (temp >= step) ? temp - step : '0;
    else if (rise && gate)
      temp <= (temp > SATV) ? MAXV : temp + HEATV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE:    if (en) state <= ST_PASS;
        ST_PASS:    if (temp >= MAXV) state <= ST_BLOCKED;
                    else if (!en) state <= ST_IDLE;
        ST_BLOCKED: if (temp < LOWV) state <= en ? ST_PASS : ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  a_r3_gate_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(gate));
  a_r6_blocked_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && blk) |=> !gate);
  a_r10_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en && !blk) |=> (single_cnt == '0 && idx == '0));
  a_r7_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (period_done && idx == ILAST && !(rise && en && !blk)) |=> idx == '0);
  a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IW'(LEN));
  a_r11_temp_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    temp <= MAXV);
  a_r8_cool_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (period_done && temp < step) |=> temp == '0);
  a_r6_enter_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PASS && temp >= MAXV) |=> blk);

endmodule

// File: tb/sim_burst_thermal_limiter.sv
module sim_burst_thermal_limiter;
  localparam int TW = 8, RES = 6, LEN = 4, MAXR = 40, LOWR = 10, HEAT = 8;
  localparam int WATCH = 150000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pin = 1'b0;
  logic pulse_out;
  int checks = 0, fails = 0, cycles = 0;
  string req = "R1";

  burst_thermal_limiter #(.TW(TW), .RES(RES), .LEN(LEN), .MAX_RISE(MAXR),
    .LOW_RISE(LOWR), .HEAT(HEAT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pulse_in(pin), .pulse_out(pulse_out));

  always #10 clk = ~clk;

  // reference model built from the requirements
  int m1, m2, m3, mg, msingle, midx, mtemp, mst;
  function automatic int cool_of(int i);
    return i + 1;
  endfunction
  function automatic int heat_sat(int t);
    return (t + HEAT > MAXR) ? MAXR : t + HEAT;
  endfunction

  always @(posedge clk) begin
    int rise, fall, blk, done;
    cycles++;
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mg = 0; msingle = 0; midx = 0; mtemp = 0; mst = 0;
    end else begin
      rise = m2 && !m3; fall = !m2 && m3; blk = (mst == 2);
      done = !m2 && msingle >= RES - 2;
      if (fall) mg = blk ? 0 : int'(en);
      case (mst)
        0: if (en) mst = 1;
        1: if (mtemp >= MAXR) mst = 2; else if (!en) mst = 0;
        default: if (mtemp < LOWR) mst = en ? 1 : 0;
      endcase
      if (done) mtemp = (mtemp >= cool_of(midx)) ? mtemp - cool_of(midx) : 0;
      else if (rise && (fall ? 0 : mg_prev)) mtemp = heat_sat(mtemp);
      if (rise && en && !blk) begin msingle = 0; midx = 0; end
      else if (!m2) begin
        if (msingle < RES - 2) msingle++;
        else begin msingle = 0; midx = (midx < LEN - 1) ? midx + 1 : 0; end
      end
      m3 = m2; m2 = m1; m1 = int'(pin);
    end
    mg_prev = mg;
  end
  int mg_prev = 0;

  always @(negedge clk) begin
    checks++;
    if (int'(pulse_out) != (mg_prev & m2)) begin
      fails++;
      $display("FAIL %s: pulse_out=%0b expected %0b at cycle %0d", req, pulse_out,
               mg_prev & m2, cycles);
    end
    if (cycles > WATCH) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCH);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(int hi, int lo);
    pin = 1'b1; wait_cyc(hi);
    pin = 1'b0; wait_cyc(lo);
  endtask

  initial begin
    void'($urandom(32'd2024));
    req = "R1"; wait_cyc(5);
    rst_n = 1'b1; wait_cyc(3);

    req = "R4"; en = 1'b0;
    for (int i = 0; i < 4; i++) pulse(4, 6);

    req = "R2"; en = 1'b1;
    pulse(4, 6);
    for (int i = 0; i < 3; i++) pulse(3 + i, 4);

    req = "R5";
    for (int i = 0; i < 4; i++) pulse(4, 2);

    req = "R6";
    for (int i = 0; i < 6; i++) pulse(4, 2);

    req = "R7"; wait_cyc(40);
    req = "R9";
    for (int i = 0; i < 4; i++) pulse(4, 3);

    req = "R8"; wait_cyc(80);
    pulse(4, 7); wait_cyc(30);

    req = "R3";
    pin = 1'b1; wait_cyc(2); en = 1'b0; wait_cyc(4); pin = 1'b0; wait_cyc(6);
    pin = 1'b1; wait_cyc(3); en = 1'b1; wait_cyc(3); pin = 1'b0; wait_cyc(6);
    pulse(5, 5);

    req = "R10";
    for (int i = 0; i < 6; i++) pulse(2, RES - 2);

    req = "R11";
    for (int i = 0; i < 12; i++) pulse(4, 1);
    for (int i = 0; i < 20; i++) pulse(1 + ($urandom % 4), RES - 3 + ($urandom % 4));

    req = "R6/R9 random";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) en = ~en;
      pulse(1 + ($urandom % 6), 1 + ($urandom % 12));
    end
    en = 1'b1;
    for (int i = 0; i < 200; i++) pulse(2, 2 + ($urandom % 8));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule